// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. Two counters run on the pixel clock. One counts pixel positions inside a line. The other counts pixel clocks from the start of the frame. Comparators on those counters make the horizontal sync, vertical sync and data-enable outputs, the active-window flag and the pixel-source select. Inside the active window the outgoing colour comes from the pixel input. Elsewhere in the display area a programmed border colour is sent, and outside the display area the colour is zero.

All vertical limits are absolute pixel-clock positions within the frame, not line numbers. Software folds the line period and the sync skew into those values before it writes them. A timing register write first lands in a shadow copy. The live copy takes the shadow at a frame boundary, so one frame never mixes old and new timing. When the pixel input is not valid inside the active window, the block sends an underflow colour. An optional recovery setting decides whether that condition clears at the next frame start.

Top module: `lcdt_top`

## Requirements
- R1: After reset, and whenever generation is stopped, the outputs sit at their inactive levels: hsync equals polarity bit 0, vsync equals polarity bit 1, de equals polarity bit 2, and pix_sel, frame_start and rgb are all 0.
- R2: Writes to word address 0 set the run flag from data bit 0, and the change takes effect at the next clock edge. The timing registers are at these word addresses: 1 line control, 2 frame period, 3 vsync width, 4 display x, 5 display y start, 6 display y end, 7 active x, 8 active y start, 9 active y end, 10 border colour, 11 underflow colour, 12 hsync skew, 13 polarity. Addresses 14 and 15 are ignored.
- R3: Line control holds the line period in bits [31:16] and the hsync width in bits [15:0]. The line counter wraps to 0 after period-1. Raw hsync is high while skew <= x < skew+width, with the skew taken from bits [15:0] of address 12.
- R4: The frame counter counts pixel clocks and wraps to 0 after frame period-1. The line counter also restarts at that wrap. frame_start is high while running and the frame counter is 0.
- R5: Raw vsync is high while the frame counter is below the vsync width register, which is a count of pixel clocks.
- R6: Raw de is high while running, x0 <= x <= x1, and y0 <= frame counter <= y1. The display x register holds x1 in bits [31:16] and x0 in bits [15:0].
- R7: The active x register holds an enable in bit 31, the end in [30:16] and the start in [14:0]. The active y start register holds an enable in bit 31 and the position in [30:0]. An axis whose enable is clear uses the display limits. pix_sel is high only inside both the display area and the active area.
- R8: Inside the display area but outside the active window, rgb equals border colour bits [23:0]. Outside the display area, rgb is 0.
- R9: Inside the active window, with pix_valid high and no underflow latched, rgb equals pix_data.
- R10: A cycle inside the active window with pix_valid low sends underflow colour bits [23:0] and latches an underflow. While the latch is set, the active window sends the underflow colour. Stopping clears the latch. With bit 31 of address 11 set, the frame wrap also clears it.
- R11: The polarity register inverts hsync with bit 0, vsync with bit 1 and de with bit 2.
- R12: Timing register writes take effect at the clock edge that ends the current frame. While stopped, they take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel input valid |
| pix_data | input | 24 | Pixel colour from the fetch path |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_sel | output | 1 | High when the colour comes from the pixel input |
| rgb | output | 24 | Outgoing colour |
| frame_start | output | 1 | High on the first pixel clock of each frame |

## Verification
The raster is first run with every pixel valid, with no active sub-window and with all polarities at zero. This shows the counter wraps, the sync widths and the display limits on their own. Enabling a sub-window on both axes then separates border colour from pixel colour. A periodic invalid-pixel pattern with recovery off shows the underflow latch holding for the rest of the run. The same pattern with recovery on shows it clearing frame by frame. Rewriting the line control mid-frame, stopping mid-frame, and changing the polarities show whether the shadow copy is applied at the frame boundary and not earlier.

// File: rtl/lcdt_pkg.sv
// Package for the raster timing generator.
// Holds the shared widths, the register addresses and the live
// configuration record. Assumes a 32-bit register data bus.
package lcdt_pkg;
    localparam int DW = 32;          // register data width
    localparam int HW = DW / 2;      // horizontal field width
    localparam int FW = DW;          // frame pixel counter width
    localparam int CW = 24;          // colour width
    localparam int AW = 4;           // register address width
    localparam int AXW = HW - 1;     // active-x field width (top bit is enable)

    typedef enum logic [AW-1:0] {
        A_RUN    = 4'd0,
        A_LINE   = 4'd1,
        A_FPER   = 4'd2,
        A_VSW    = 4'd3,
        A_DISPX  = 4'd4,
        A_DISPY0 = 4'd5,
        A_DISPY1 = 4'd6,
        A_ACTX   = 4'd7,
        A_ACTY0  = 4'd8,
        A_ACTY1  = 4'd9,
        A_BORDER = 4'd10,
        A_UFLOW  = 4'd11,
        A_SKEW   = 4'd12,
        A_POL    = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic [HW-1:0] line_per;
        logic [HW-1:0] hs_width;
        logic [HW-1:0] skew;
        logic [HW-1:0] disp_x0;
        logic [HW-1:0] disp_x1;
        logic          act_x_en;
        logic [HW-1:0] act_x0;
        logic [HW-1:0] act_x1;
        logic [FW-1:0] frame_per;
        logic [FW-1:0] vs_width;
        logic [FW-1:0] disp_y0;
        logic [FW-1:0] disp_y1;
        logic          act_y_en;
        logic [FW-1:0] act_y0;
        logic [FW-1:0] act_y1;
        logic [CW-1:0] border;
        logic [CW-1:0] uflow;
        logic          recover;
        logic [2:0]    pol;
    } tcfg_t;
endpackage

// File: rtl/lcdt_regs.sv
// Register store for the raster timing generator.
// Writes to timing fields land in a shadow record. The live record takes
// the whole shadow when stopped or at the frame wrap. The run flag
// is written directly. Assumes single-cycle writes with no readback.
module lcdt_regs
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_wrap,
    output logic          run,
    output tcfg_t         live
);
    tcfg_t shadow;

    // Run flag: written directly, no shadowing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (wr_en && wr_addr == A_RUN)
            run <= wr_data[0];
    end

    // Shadow record: decode a write into its fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_LINE: begin
                    shadow.line_per <= wr_data[DW-1:HW];
                    shadow.hs_width <= wr_data[HW-1:0];
                end
                A_FPER:   shadow.frame_per <= wr_data[FW-1:0];
                A_VSW:    shadow.vs_width  <= wr_data[FW-1:0];
                A_DISPX: begin
                    shadow.disp_x1 <= wr_data[DW-1:HW];
                    shadow.disp_x0 <= wr_data[HW-1:0];
                end
                A_DISPY0: shadow.disp_y0 <= wr_data[FW-1:0];
                A_DISPY1: shadow.disp_y1 <= wr_data[FW-1:0];
                A_ACTX: begin
                    shadow.act_x_en <= wr_data[DW-1];
                    shadow.act_x1   <= {1'b0, wr_data[HW+AXW-1:HW]};
                    shadow.act_x0   <= {1'b0, wr_data[AXW-1:0]};
                end
                A_ACTY0: begin
                    shadow.act_y_en <= wr_data[DW-1];
                    shadow.act_y0   <= {1'b0, wr_data[FW-2:0]};
                end
                A_ACTY1:  shadow.act_y1 <= wr_data[FW-1:0];
                A_BORDER: shadow.border <= wr_data[CW-1:0];
                A_UFLOW: begin
                    shadow.recover <= wr_data[DW-1];
                    shadow.uflow   <= wr_data[CW-1:0];
                end
                A_SKEW:   shadow.skew <= wr_data[HW-1:0];
                A_POL:    shadow.pol  <= wr_data[2:0];
                default:  ;
            endcase
        end
    end

    // Live record: copy the whole shadow when stopped or at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live <= '0;
        else if (!run || frame_wrap)
            live <= shadow;
    end

    // Live timing must not move during a running frame.
    assert_live_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_wrap) |=> $stable(live));
endmodule

// File: rtl/lcdt_scan.sv
// Line and frame counters for the raster timing generator.
// The line counter wraps at line period minus one. The frame counter
// counts pixel clocks and wraps at frame period minus one. It also
// restarts the line counter. Both counters stay at zero while stopped.
module lcdt_scan
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] line_per,
    input  logic [FW-1:0] frame_per,
    output logic [HW-1:0] hpos,
    output logic [FW-1:0] fpos,
    output logic          frame_wrap
);
    logic line_end;

    // Terminal-count detection for both counters.
    always_comb begin
        frame_wrap = run && (fpos == frame_per - 1'b1);
        line_end   = (hpos == line_per - 1'b1);
    end

    // Counter advance with wrap and the stopped hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hpos <= '0;
            fpos <= '0;
        end else begin
            fpos <= frame_wrap ? '0 : fpos + 1'b1;
            hpos <= (frame_wrap || line_end) ? '0 : hpos + 1'b1;
        end
    end

    assert_hwrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && line_end && !frame_wrap) |=> hpos == '0);
    assert_fwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (fpos == '0 && hpos == '0));
    assert_stop_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (fpos == '0 && hpos == '0));
endmodule

// File: rtl/lcdt_pixout.sv
// Output stage for the raster timing generator.
// Compares the counters against the live limits to make the syncs, the
// display and active windows, and the colour mux. Holds the underflow latch.
// Outputs are combinational from registered counters and configuration.
module lcdt_pixout
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] hpos,
    input  logic [FW-1:0] fpos,
    input  logic          frame_wrap,
    input  tcfg_t         cfg,
    input  logic          pix_valid,
    input  logic [CW-1:0] pix_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_sel,
    output logic [CW-1:0] rgb,
    output logic          frame_start
);
    logic          hs_raw, vs_raw, disp, in_dx, in_dy, in_ax, in_ay, act;
    logic          uf_latched;
    logic [HW:0]   hs_end;

    // Sync and window comparisons against the counters.
    always_comb begin
        hs_end = {1'b0, cfg.skew} + {1'b0, cfg.hs_width};
        hs_raw = run && ({1'b0, hpos} >= {1'b0, cfg.skew}) && ({1'b0, hpos} < hs_end);
        vs_raw = run && (fpos < cfg.vs_width);
        in_dx  = (hpos >= cfg.disp_x0) && (hpos <= cfg.disp_x1);
        in_dy  = (fpos >= cfg.disp_y0) && (fpos <= cfg.disp_y1);
        in_ax  = cfg.act_x_en ? ((hpos >= cfg.act_x0) && (hpos <= cfg.act_x1)) : in_dx;
        in_ay  = cfg.act_y_en ? ((fpos >= cfg.act_y0) && (fpos <= cfg.act_y1)) : in_dy;
        disp   = run && in_dx && in_dy;
        act    = disp && in_ax && in_ay;
    end

    // Underflow latch: set on a starved active pixel, cleared by stop or recovery.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            uf_latched <= 1'b0;
        else if (frame_wrap && cfg.recover)
            uf_latched <= 1'b0;
        else if (act && !pix_valid)
            uf_latched <= 1'b1;
    end

    // Polarity, pixel-source select and colour selection.
    always_comb begin
        hsync       = hs_raw ^ cfg.pol[0];
        vsync       = vs_raw ^ cfg.pol[1];
        de          = disp   ^ cfg.pol[2];
        pix_sel     = act;
        frame_start = run && (fpos == '0);
        if (!disp)
            rgb = '0;
        else if (!act)
            rgb = cfg.border;
        else if (!pix_valid || uf_latched)
            rgb = cfg.uflow;
        else
            rgb = pix_data;
    end

    assert_sel_in_disp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sel |-> disp);
    assert_uf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && uf_latched && !(frame_wrap && cfg.recover)) |=> uf_latched);
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pix_sel && rgb == '0 && !frame_start));
endmodule

// File: rtl/lcdt_top.sv
// Top level of the LCD raster timing generator.
// Joins the register store, the scan counters and the output stage.
// Assumes one pixel per clock and a register write port with no readback.
module lcdt_top
    import lcdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          pix_valid,
    input  logic [CW-1:0] pix_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_sel,
    output logic [CW-1:0] rgb,
    output logic          frame_start
);
    logic          run, frame_wrap;
    tcfg_t         live;
    logic [HW-1:0] hpos;
    logic [FW-1:0] fpos;

    lcdt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_wrap(frame_wrap), .run(run), .live(live)
    );

    lcdt_scan u_scan (
        .clk(clk), .rst_n(rst_n), .run(run), .line_per(live.line_per),
        .frame_per(live.frame_per), .hpos(hpos), .fpos(fpos),
        .frame_wrap(frame_wrap)
    );

    lcdt_pixout u_out (
        .clk(clk), .rst_n(rst_n), .run(run), .hpos(hpos), .fpos(fpos),
        .frame_wrap(frame_wrap), .cfg(live), .pix_valid(pix_valid),
        .pix_data(pix_data), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_sel(pix_sel), .rgb(rgb), .frame_start(frame_start)
    );
endmodule

// File: tb/lcdt_top_test.sv
// Bench for lcdt_top: a behavioural model of the raster, compared on every clock.
module lcdt_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_valid = 1'b1;
    logic [23:0] pix_data = '0;
    logic        hsync, vsync, de, pix_sel, frame_start;
    logic [23:0] rgb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int starve_mode = 0;
    bit done = 1'b0;

    // Model state.
    logic [31:0] sh [0:15];
    logic [31:0] lv [0:15];
    logic        m_run;
    logic [15:0] m_h;
    logic [31:0] m_f;
    logic        m_uf;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdt_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_valid(pix_valid), .pix_data(pix_data),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_sel(pix_sel),
        .rgb(rgb), .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            sh[i] = '0;
            lv[i] = '0;
        end
        m_run = 0; m_h = '0; m_f = '0; m_uf = 0;
    endtask

    // One clock: drive pixel input, compare, advance the model, move to next negedge.
    task automatic step();
        int hh, ff, sk, hw, x0, x1, ax0, ax1;
        longint y0, y1, ay0, ay1, vsw;
        bit hs, vs, dx, dy, ax, ay, disp, act, fw;
        logic [23:0] exp_rgb;
        logic [2:0] pol;
        pix_data  = 24'(cyc * 40503 + 17);
        pix_valid = (starve_mode == 0) ? 1'b1 : ((cyc % 23) != 5);
        #1;
        hh = m_h; ff = m_f;
        hw = lv[1][15:0]; sk = lv[12][15:0];
        x0 = lv[4][15:0]; x1 = lv[4][31:16];
        ax0 = lv[7][14:0]; ax1 = lv[7][30:16];
        y0 = lv[5]; y1 = lv[6]; ay0 = lv[8][30:0]; ay1 = lv[9]; vsw = lv[3];
        pol = lv[13][2:0];
        hs = m_run && hh >= sk && hh < sk + hw;
        vs = m_run && longint'(ff) < vsw;
        dx = hh >= x0 && hh <= x1;
        dy = m_f >= y0 && m_f <= y1;
        ax = lv[7][31] ? (hh >= ax0 && hh <= ax1) : dx;
        ay = lv[8][31] ? (m_f >= ay0 && m_f <= ay1) : dy;
        disp = m_run && dx && dy;
        act = disp && ax && ay;
        if (!disp) exp_rgb = '0;
        else if (!act) exp_rgb = lv[10][23:0];
        else if (!pix_valid || m_uf) exp_rgb = lv[11][23:0];
        else exp_rgb = pix_data;
        chk(hsync == (hs ^ pol[0]), "R3/R11", "hsync", hsync, hs ^ pol[0]);
        chk(vsync == (vs ^ pol[1]), "R5/R11", "vsync", vsync, vs ^ pol[1]);
        chk(de == (disp ^ pol[2]), "R6/R11", "de", de, disp ^ pol[2]);
        chk(pix_sel == act, "R7", "pix_sel", pix_sel, act);
        chk(frame_start == (m_run && m_f == 0), "R4", "frame_start", frame_start, m_run && m_f == 0);
        chk(rgb == exp_rgb, "R8/R9/R10", "rgb", rgb, exp_rgb);
        // Model advance (R4, R10, R12, R2).
        fw = m_run && (m_f == lv[2] - 32'd1);
        if (!m_run) m_uf = 0;
        else if (fw && lv[11][31]) m_uf = 0;
        else if (act && !pix_valid) m_uf = 1;
        if (!m_run) begin
            m_h = '0; m_f = '0;
        end else begin
            m_h = (fw || m_h == lv[1][31:16] - 16'd1) ? 16'd0 : m_h + 16'd1;
            m_f = fw ? 32'd0 : m_f + 32'd1;
        end
        if (!m_run || fw)
            for (int i = 0; i < 16; i++) lv[i] = sh[i];
        if (wr_en) begin
            if (wr_addr == 4'd0) m_run = wr_data[0];
            else if (wr_addr <= 4'd13) sh[wr_addr] = wr_data;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        model_reset();
        // R1: reset state
        chk(hsync == 0 && vsync == 0 && de == 0, "R1", "syncs at reset", {hsync, vsync, de}, 0);
        chk(pix_sel == 0 && frame_start == 0 && rgb == 0, "R1", "select/colour at reset", rgb, 0);
        rst_n = 1;
        // R2: register map; 13-clock lines, 7-line frame.
        wr(4'd1, {16'd13, 16'd2});
        wr(4'd2, 32'd91);
        wr(4'd3, 32'd13);
        wr(4'd4, {16'd10, 16'd5});
        wr(4'd5, 32'd27);
        wr(4'd6, 32'd78);
        wr(4'd10, 32'h00A0B0C0);
        wr(4'd11, 32'h00112233);
        wr(4'd12, 32'd1);
        wr(4'd13, 32'd0);
        wr(4'd14, 32'hFFFF_FFFF);   // R2: ignored address
        wr(4'd0, 32'd1);
        run_cycles(300);
        // R7/R8: sub-window on both axes, written while running (R12).
        wr(4'd7, 32'h8008_0006);
        wr(4'd8, 32'h8000_0028);
        wr(4'd9, 32'd65);
        run_cycles(200);
        // R10: starved pixels, no recovery.
        starve_mode = 1;
        run_cycles(300);
        // R1: stop mid-frame, then change polarity and enable recovery.
        wr(4'd0, 32'd0);
        run_cycles(5);
        wr(4'd13, 32'd5);
        run_cycles(3);
        wr(4'd11, 32'h8011_2233);
        wr(4'd0, 32'd1);
        run_cycles(300);
        // R12: line control rewritten mid-frame.
        wr(4'd1, {16'd13, 16'd3});
        wr(4'd13, 32'd2);
        run_cycles(250);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule